// File: doc/BRIEF.md
# Load/Store Address Unit with Base Writeback

This block serves the memory stage of a 16-bit, word-addressed processor. For every decoded load or store it forms the data-memory address, drives the memory port, and commits the register results. The addressing choices are: the base register alone, base plus offset with the base left as it was, pre-update (the access uses base plus offset and that sum becomes the new base), and post-update (the access uses the old base and the sum becomes the new base). The offset is either another register or a small signed immediate.

A register file with two write ports sits inside the block. One write port carries load data and the other carries the updated base, so a pre- or post-update access finishes in a single cycle. When both ports name the same register, the load data is written. The memory port is single-cycle. Address, write data and write enable depend combinationally on the current instruction. Read data is expected back within the same cycle. All register writes commit on the rising clock edge that ends the instruction. A fourth read port lets the surrounding pipeline, or a bench, read any register.

Top module: `ldst_agu`

## Requirements
- R1: While `rst` is high on a clock edge, every register is cleared to 0. With `ins_valid` low, `mem_we` is low.
- R2: Mode 2'b00 (direct) accesses the address held in register `ins_rb` and leaves that register unchanged.
- R3: Mode 2'b01 (indexed) accesses base plus offset and leaves the base register unchanged.
- R4: When `ins_use_imm` is 1, the offset is `ins_imm` read as a 4-bit two's-complement value and sign-extended to 16 bits (4'hF means -1). All address sums wrap modulo 2^16.
- R5: When `ins_use_imm` is 0, the offset is the value of register `ins_ro`.
- R6: Mode 2'b11 (post-update) accesses the old base address and writes base plus offset into `ins_rb` on the same edge.
- R7: Mode 2'b10 (pre-update) accesses base plus offset and writes that same sum into `ins_rb` on the same edge.
- R8: A valid load (`ins_store` = 0) writes `mem_rdata`, sampled in its cycle, into register `ins_rd` at the end of that cycle.
- R9: If a pre- or post-update load has `ins_rd` equal to `ins_rb`, the register ends up holding the loaded data, not the updated base.
- R10: A valid store raises `mem_we` only in its own cycle. It drives `mem_wdata` with the value `ins_rd` held before that cycle's updates, including when `ins_rd` equals `ins_rb` in an update mode. Apart from any base writeback, it changes no register.
- R11: With `ins_valid` low, `mem_we` stays low and no register changes, whatever the other instruction fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Decoded instruction present this cycle |
| ins_store | input | 1 | 1 = store, 0 = load |
| ins_mode | input | 2 | 00 direct, 01 indexed, 10 pre-update, 11 post-update |
| ins_use_imm | input | 1 | Offset from immediate (1) or register (0) |
| ins_rd | input | 3 | Load destination / store source register |
| ins_rb | input | 3 | Base register |
| ins_ro | input | 3 | Offset register |
| ins_imm | input | 4 | Signed immediate offset |
| mem_addr | output | 16 | Data memory word address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 16 | Load data, valid in the same cycle |
| dbg_sel | input | 3 | Register selected for observation |
| dbg_data | output | 16 | Value of the selected register |

## Verification
The bench targets loads whose destination is also the base register in both update modes. A design that gives the wrong write port priority would leave the updated base there instead of the loaded word. It runs a post-update store of the base register itself, where a design that forwards the new base would store the wrong word. It also runs a base near 16'hFFFF with a positive immediate and an immediate of 4'hF, which catch missing wraparound and zero-extension of the immediate. Idle cycles carry store-like fields to show that a strobe leaking from `ins_store` alone would corrupt memory.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT  = 2'b00,
    AM_INDEXED = 2'b01,
    AM_PREUPD  = 2'b10,
    AM_POSTUPD = 2'b11
  } amode_e;
endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NRD-1:0][AW-1:0]   rd_sel,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  input  logic                     wa_en,
  input  logic [AW-1:0]            wa_sel,
  input  logic [DW-1:0]            wa_data,
  input  logic                     wb_en,
  input  logic [AW-1:0]            wb_sel,
  input  logic [DW-1:0]            wb_data
);
  logic [DW-1:0] regs [NREG];

  // Port A is assigned last, so it overrides port B on the same register.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wb_en) regs[wb_sel] <= wb_data;
      if (wa_en) regs[wa_sel] <= wa_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = regs[rd_sel[g]];
  end
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen import ldst_pkg::*; #(
  parameter int DW    = 16,
  parameter int IMM_W = 4
) (
  input  amode_e           mode,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    base_val,
  input  logic [DW-1:0]    off_reg,
  output logic [DW-1:0]    acc_addr,
  output logic [DW-1:0]    new_base,
  output logic             base_upd
);
  logic [DW-1:0] off_ext;
  logic [DW-1:0] sum;

  assign off_ext  = use_imm ? {{(DW-IMM_W){imm[IMM_W-1]}}, imm} : off_reg;
  assign sum      = base_val + off_ext;
  assign new_base = sum;

  always_comb begin
    acc_addr = base_val;
    base_upd = 1'b0;
    unique case (mode)
      AM_DIRECT:  acc_addr = base_val;
      AM_INDEXED: acc_addr = sum;
      AM_PREUPD:  begin acc_addr = sum;      base_upd = 1'b1; end
      AM_POSTUPD: begin acc_addr = base_val; base_upd = 1'b1; end
      default:    acc_addr = base_val;
    endcase
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu import ldst_pkg::*; #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int IMM_W = 4,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic             ins_store,
  input  logic [1:0]       ins_mode,
  input  logic             ins_use_imm,
  input  logic [RW-1:0]    ins_rd,
  input  logic [RW-1:0]    ins_rb,
  input  logic [RW-1:0]    ins_ro,
  input  logic [IMM_W-1:0] ins_imm,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [RW-1:0]    dbg_sel,
  output logic [DW-1:0]    dbg_data
);
  localparam int NRD = 4;

  logic [NRD-1:0][RW-1:0] rsel;
  logic [NRD-1:0][DW-1:0] rdat;
  logic [DW-1:0] base_val, off_val, src_val;
  logic [DW-1:0] acc_addr, new_base;
  logic          base_upd, wa_en, wb_en;

  assign rsel     = {dbg_sel, ins_rd, ins_ro, ins_rb};
  assign base_val = rdat[0];
  assign off_val  = rdat[1];
  assign src_val  = rdat[2];
  assign dbg_data = rdat[3];

  ldst_addr_gen #(.DW(DW), .IMM_W(IMM_W)) u_agen (
    .mode     (amode_e'(ins_mode)),
    .use_imm  (ins_use_imm),
    .imm      (ins_imm),
    .base_val (base_val),
    .off_reg  (off_val),
    .acc_addr (acc_addr),
    .new_base (new_base),
    .base_upd (base_upd)
  );

  assign wa_en     = ins_valid & ~ins_store;
  assign wb_en     = ins_valid & base_upd;
  assign mem_addr  = acc_addr;
  assign mem_wdata = src_val;
  assign mem_we    = ins_valid & ins_store;

  ldst_regfile #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (rsel),
    .rd_data (rdat),
    .wa_en   (wa_en),
    .wa_sel  (ins_rd),
    .wa_data (mem_rdata),
    .wb_en   (wb_en),
    .wb_sel  (ins_rb),
    .wb_data (new_base)
  );
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int DW    = 16,
  parameter int RW    = 3,
  parameter int IMM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             ins_store,
  input logic [1:0]       ins_mode,
  input logic             ins_use_imm,
  input logic [IMM_W-1:0] ins_imm,
  input logic [DW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_we,
  input logic [DW-1:0]    base_val,
  input logic [DW-1:0]    src_val,
  input logic             wa_en,
  input logic             wb_en
);
  // R2: direct mode addresses the register-file base value
  a_r2_direct_addr: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_mode == 2'b00) |-> mem_addr == base_val);

  // R6: post-update accesses the old base
  a_r6_post_addr: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_mode == 2'b11) |-> mem_addr == base_val);

  // R7: a nonzero immediate pre-update moves the access away from the base
  a_r7_pre_moves: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_mode == 2'b10 && ins_use_imm && ins_imm != '0)
      |-> mem_addr != base_val);

  // R3: direct and indexed modes never request a base writeback
  a_r3_no_base_write: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_mode[1]) |-> !wb_en);

  // R10: stores drive the source register value and never load
  a_r10_store_data: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == src_val && !wa_en));

  // R11: idle cycles write nothing
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |-> (!mem_we && !wa_en && !wb_en));
endmodule

bind ldst_agu ldst_agu_chk #(.DW(DW), .RW(RW), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/ldst_agu_bench.sv
module ldst_agu_bench;
  localparam int DW = 16;
  localparam int RW = 3;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          ins_valid = 1'b0, ins_store = 1'b0, ins_use_imm = 1'b0;
  logic [1:0]    ins_mode = 2'b00;
  logic [RW-1:0] ins_rd = '0, ins_rb = '0, ins_ro = '0, dbg_sel = '0;
  logic [IW-1:0] ins_imm = '0;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic          mem_we;

  logic [15:0] bmem [256];
  logic [15:0] mmem [256];
  logic [15:0] mreg [8];
  int n_chk = 0;
  int n_bad = 0;

  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

  ldst_agu u_ldst_agu (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_store(ins_store),
    .ins_mode(ins_mode), .ins_use_imm(ins_use_imm), .ins_rd(ins_rd),
    .ins_rb(ins_rb), .ins_ro(ins_ro), .ins_imm(ins_imm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i);
      #1;
      chk(tag, $sformatf("reg%0d", i), {16'h0, dbg_data}, {16'h0, mreg[i]});
    end
  endtask

  task automatic run_op(input bit st, input bit [1:0] md, input bit ui,
                        input int rd, input int rb, input int ro,
                        input bit [3:0] im, input string tag);
    logic [15:0] b, o, addr, nb, ldv;
    bit upd;
    @(negedge clk);
    ins_valid = 1'b1; ins_store = st; ins_mode = md; ins_use_imm = ui;
    ins_rd = 3'(rd); ins_rb = 3'(rb); ins_ro = 3'(ro); ins_imm = im;
    b  = mreg[rb];
    o  = ui ? {{12{im[3]}}, im} : mreg[ro];
    nb = b + o;
    upd = md[1];
    addr = (md == 2'b01 || md == 2'b10) ? nb : b;
    #2;
    chk(tag, "addr", {16'h0, mem_addr}, {16'h0, addr});
    chk(tag, "we", {31'h0, mem_we}, {31'h0, st});
    if (st) chk(tag, "wdata", {16'h0, mem_wdata}, {16'h0, mreg[rd]});
    ldv = mmem[addr[7:0]];
    if (st) mmem[addr[7:0]] = mreg[rd];
    if (upd) mreg[rb] = nb;
    if (!st) mreg[rd] = ldv;
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    sweep(tag);
  endtask

  task automatic idle_op();
    @(negedge clk);
    ins_valid = 1'b0; ins_store = 1'b1; ins_mode = 2'b10; ins_use_imm = 1'b1;
    ins_rd = 3'd1; ins_rb = 3'd2; ins_imm = 4'h3;
    #2;
    chk("R11", "we", {31'h0, mem_we}, 32'h0);
    @(posedge clk);
    #1;
    sweep("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 16'(i * 291 + 5);
      mmem[i] = 16'(i * 291 + 5);
    end
    bmem[3] = 16'hFFFE; mmem[3] = 16'hFFFE;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "we", {31'h0, mem_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    sweep("R1");

    for (int k = 1; k < 8; k++) run_op(0, 2'b01, 1, k, 0, 0, 4'(k), "R3");
    run_op(0, 2'b00, 0, 2, 0, 0, 4'h0, "R8");
    run_op(0, 2'b00, 0, 1, 5, 0, 4'h0, "R2");
    run_op(0, 2'b01, 1, 4, 3, 0, 4'h5, "R4");
    run_op(0, 2'b01, 1, 5, 2, 0, 4'hF, "R4");
    run_op(0, 2'b01, 0, 6, 2, 7, 4'h0, "R5");
    run_op(0, 2'b11, 1, 1, 2, 0, 4'h2, "R6");
    run_op(0, 2'b10, 0, 5, 6, 7, 4'h0, "R7");
    run_op(0, 2'b10, 1, 4, 4, 0, 4'h3, "R9");
    run_op(0, 2'b11, 1, 7, 7, 0, 4'h9, "R9");
    run_op(1, 2'b00, 0, 2, 1, 0, 4'h0, "R10");
    run_op(1, 2'b11, 1, 3, 3, 0, 4'h1, "R10");
    run_op(1, 2'b10, 1, 5, 6, 0, 4'hE, "R10");
    run_op(0, 2'b00, 0, 0, 1, 0, 4'h0, "R10");
    idle_op();
    idle_op();

    lf = 16'hACE1;
    for (int n = 0; n < 120; n++) begin
      string tg;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) tg = "R10";
      else case (lf[2:1])
        2'b00: tg = "R2";
        2'b01: tg = "R3";
        2'b10: tg = "R7";
        default: tg = "R6";
      endcase
      run_op(lf[0], lf[2:1], lf[3], int'(lf[6:4]), int'(lf[9:7]),
             int'(lf[12:10]), lf[15:12], tg);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule